// File: doc/BRIEF.md
# Key Event Queue with Peek

This block holds keypad events in a sixteen-entry circular queue and raises an interrupt when new events arrive. A producer hands in one event per cycle as a 7-bit key code plus a press/release bit; each accepted event is stored as one byte, with the code in bits 6:0 and the press bit in bit 7. A command interface reads events back in two ways. A popping read moves the queue head forward and returns the entry found at the new head. A peek read returns the entry at a byte offset from the head and leaves the queue untouched.

The push side is valid/ready. `key_ready` drops when the queue holds sixteen entries or when overflow suppression is active. A beat offered while `key_ready` is low is dropped, not held, so the producer need not wait. If the queue was simply full, dropping the beat raises an overrun. If suppression was active, the beat is dropped with no further effect. The read side is request/response: a request made in one cycle gets a one-cycle `rd_rsp_valid` pulse with its data on the next clock edge. The response has no back-pressure. Separate plain inputs clear the whole queue (a configuration write) and clear the status flags (an interrupt acknowledge).

Top module: `key_event_queue`

## Requirements
- R1: An accepted push stores `{key_press, key_code}` at the tail (bit 7 = press, bits 6:0 = code) and raises `count` by one in the next cycle.
- R2: `key_ready` is low whenever `count` is 16 or both `err_flag` and `ovf_err` are set. A beat offered while it is low is discarded, not held.
- R3: A push offered while `count` is 16, with suppression inactive, leaves `count` at 16 and sets both `ovf_err` and `err_flag`.
- R4: While `err_flag` and `ovf_err` are both set, offered pushes change neither the stored entries, `count` nor any flag.
- R5: An accepted push sets `kp_event`. `irq` is high whenever `kp_event` or `err_flag` is set.
- R6: A popping read (`rd_req`=1, `rd_peek`=0) with `count` of 0 or 1 returns 0x00 and changes no state.
- R7: A popping read with `count` of at least 2 advances the head by one, lowers `count` by one and returns the entry at the new head.
- R8: A peek read (`rd_req`=1, `rd_peek`=1) at index i returns 0x00 when i is at least `count`. Otherwise it returns the entry at (head + i) mod 16. In both cases state is unchanged.
- R9: `cfg_clear` sets head and `count` to zero and clears `kp_event` and `err_flag`. A push or read offered in the same cycle is ignored and gives no response. `ovf_err` is kept.
- R10: A push and a pop in the same cycle both take effect and leave `count` unchanged. Whether the push is accepted is judged on the count before that cycle, so at 16 the push still overflows.
- R11: `status_clr` clears `kp_event` and `err_flag`, but a setting event in the same cycle wins. `ovf_err` is cleared only by reset.
- R12: After reset, `count` is 0, all flags and `irq` are low, `key_ready` is high and no response is pending. Each read request yields exactly one `rd_rsp_valid` pulse in the next cycle.
- R13: Head and tail wrap modulo 16, so peeks and pops read correctly across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Queue can accept the offered event |
| key_code | input | 7 | Key code |
| key_press | input | 1 | 1 = press, 0 = release |
| rd_req | input | 1 | Read request |
| rd_peek | input | 1 | 0 = popping read, 1 = peek read |
| rd_index | input | 5 | Byte offset from head for a peek |
| rd_rsp_valid | output | 1 | Read response strobe (one cycle after request) |
| rd_rsp_data | output | 8 | Read response byte |
| cfg_clear | input | 1 | Empty the queue and clear status |
| status_clr | input | 1 | Acknowledge: clear keypad and error status |
| count | output | 5 | Number of stored entries (0..16) |
| kp_event | output | 1 | Keypad-event status |
| err_flag | output | 1 | Error status |
| ovf_err | output | 1 | Sticky queue-overrun error |
| irq | output | 1 | Interrupt, high when any status bit is set |

## Verification
The bench checks a popping read at counts of zero and one, where a design that popped anyway would return stale bytes and corrupt the count. It peeks at index 16 on a full queue, where a design that compared indices with truncated widths would return the head entry instead of zero. It fills the queue and pushes into it with suppression both off and on, which shows a design that wraps over old entries, counts past 16, or keeps refusing after the acknowledge. It also issues a pop and a push in the same cycle, both when the queue is full and when it is not. This catches a design that judges fullness after the pop, or one that writes the new tail where the pop reads.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  typedef enum logic [1:0] {
    RQ_NONE = 2'd0,
    RQ_POP  = 2'd1,
    RQ_PEEK = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/keyq_ctrl.sv
module keyq_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_clear,
  input  logic             push_req,
  input  logic             suppress,
  input  keyq_pkg::rd_kind_e rd_kind,
  input  logic [CNT_W-1:0] peek_idx,
  output logic             push_ok,
  output logic             ovf_evt,
  output logic             rd_hit,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_addr,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  import keyq_pkg::*;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok;

  assign full    = (cnt_q == CNT_FULL);
  assign push_ok = push_req & ~full & ~suppress & ~cfg_clear;
  assign ovf_evt = push_req &  full & ~suppress & ~cfg_clear;
  assign pop_ok  = (rd_kind == RQ_POP) & ~cfg_clear & (cnt_q > CNT_ONE);
  assign wr_ptr  = head_q + cnt_q[PTR_W-1:0];
  assign rd_addr = (rd_kind == RQ_POP) ? head_q + PTR_W'(1)
                                       : head_q + peek_idx[PTR_W-1:0];
  assign rd_hit  = pop_ok | ((rd_kind == RQ_PEEK) & ~cfg_clear & (peek_idx < cnt_q));
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_clear) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_ok) head_q <= head_q + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_ONE;
        2'b01:   cnt_q <= cnt_q - CNT_ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/keyq_store.sv
module keyq_store #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [ENT_W-1:0] rd_data
);
  logic [ENT_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   slot_q[g] <= '0;
      else if (wr_en && wr_ptr == PTR_W'(g))        slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/keyq_flags.sv
module keyq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_clear,
  input  logic status_clr,
  input  logic push_ok,
  input  logic ovf_evt,
  output logic kp_event,
  output logic err_flag,
  output logic ovf_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kp_event <= 1'b0;
      err_flag <= 1'b0;
      ovf_err  <= 1'b0;
    end else begin
      if (cfg_clear)       kp_event <= 1'b0;
      else if (push_ok)    kp_event <= 1'b1;
      else if (status_clr) kp_event <= 1'b0;

      if (cfg_clear)       err_flag <= 1'b0;
      else if (ovf_evt)    err_flag <= 1'b1;
      else if (status_clr) err_flag <= 1'b0;

      if (ovf_evt) ovf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  localparam int ENT_W = CODE_W + 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [CODE_W-1:0] key_code,
  input  logic              key_press,
  input  logic              rd_req,
  input  logic              rd_peek,
  input  logic [CNT_W-1:0]  rd_index,
  output logic              rd_rsp_valid,
  output logic [ENT_W-1:0]  rd_rsp_data,
  input  logic              cfg_clear,
  input  logic              status_clr,
  output logic [CNT_W-1:0]  count,
  output logic              kp_event,
  output logic              err_flag,
  output logic              ovf_err,
  output logic              irq
);
  import keyq_pkg::*;

  rd_kind_e         rd_kind;
  logic             push_ok, ovf_evt, rd_hit, full, suppress;
  logic [PTR_W-1:0] wr_ptr, rd_addr;
  logic [ENT_W-1:0] mem_rd;

  assign rd_kind   = !rd_req ? RQ_NONE : (rd_peek ? RQ_PEEK : RQ_POP);
  assign suppress  = err_flag & ovf_err;
  assign key_ready = ~full & ~suppress;
  assign irq       = kp_event | err_flag;

  keyq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .push_req(key_valid),
    .suppress(suppress), .rd_kind(rd_kind), .peek_idx(rd_index),
    .push_ok(push_ok), .ovf_evt(ovf_evt), .rd_hit(rd_hit), .wr_ptr(wr_ptr),
    .rd_addr(rd_addr), .full(full), .count(count)
  );

  keyq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_ptr(wr_ptr),
    .wr_data({key_press, key_code}), .rd_addr(rd_addr), .rd_data(mem_rd)
  );

  keyq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .status_clr(status_clr),
    .push_ok(push_ok), .ovf_evt(ovf_evt), .kp_event(kp_event),
    .err_flag(err_flag), .ovf_err(ovf_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      rd_rsp_valid <= (rd_kind != RQ_NONE) & ~cfg_clear;
      rd_rsp_data  <= rd_hit ? mem_rd : '0;
    end
  end
endmodule

// File: rtl/keyq_checker.sv
module keyq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int ENT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_valid,
  input logic             key_ready,
  input logic             rd_req,
  input logic             rd_peek,
  input logic [CNT_W-1:0] rd_index,
  input logic             rd_rsp_valid,
  input logic [ENT_W-1:0] rd_rsp_data,
  input logic             cfg_clear,
  input logic [CNT_W-1:0] count,
  input logic             kp_event,
  input logic             err_flag,
  input logic             ovf_err
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready |-> (count != CNT_FULL));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && count == CNT_FULL && !(err_flag && ovf_err) && !cfg_clear && !rd_req)
    |=> (count == CNT_FULL && ovf_err && err_flag));

  p_suppress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && err_flag && ovf_err && !cfg_clear && !rd_req)
    |=> (count == $past(count)));

  p_push_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready && !cfg_clear) |=> kp_event);

  p_pop_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_peek && count <= CNT_W'(1) && !cfg_clear && !key_valid)
    |=> (rd_rsp_valid && rd_rsp_data == '0 && count == $past(count)));

  p_peek_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_peek && rd_index >= count && !cfg_clear)
    |=> (rd_rsp_valid && rd_rsp_data == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (count == '0 && !kp_event && !err_flag && !rd_rsp_valid));

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

bind key_event_queue keyq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ENT_W(ENT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
  .rd_req(rd_req), .rd_peek(rd_peek), .rd_index(rd_index),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .cfg_clear(cfg_clear),
  .count(count), .kp_event(kp_event), .err_flag(err_flag), .ovf_err(ovf_err)
);

// File: tb/key_event_queue_tb_top.sv
module key_event_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {op[1:0] (0 push,1 pop,2 peek), entry[7:0], idx[4:0], exp_count[4:0], exp_rsp[7:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {2'd1, 8'h00, 5'd0, 5'd0, 8'h00},
    {2'd0, 8'hBC, 5'd0, 5'd1, 8'h00},
    {2'd1, 8'h00, 5'd0, 5'd1, 8'h00},
    {2'd2, 8'h00, 5'd0, 5'd1, 8'hBC},
    {2'd2, 8'h00, 5'd1, 5'd1, 8'h00},
    {2'd0, 8'h55, 5'd0, 5'd2, 8'h00},
    {2'd2, 8'h00, 5'd1, 5'd2, 8'h55},
    {2'd1, 8'h00, 5'd0, 5'd1, 8'h55},
    {2'd2, 8'h00, 5'd0, 5'd1, 8'h55},
    {2'd0, 8'h92, 5'd0, 5'd2, 8'h00},
    {2'd2, 8'h00, 5'd1, 5'd2, 8'h92}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic key_valid = 1'b0, key_press = 1'b0, rd_req = 1'b0, rd_peek = 1'b0;
  logic cfg_clear = 1'b0, status_clr = 1'b0;
  logic [6:0] key_code = '0;
  logic [4:0] rd_index = '0;
  logic key_ready, rd_rsp_valid, kp_event, err_flag, ovf_err, irq;
  logic [7:0] rd_rsp_data;
  logic [4:0] count;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_event_queue dut_i (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .key_press(key_press), .rd_req(rd_req), .rd_peek(rd_peek),
    .rd_index(rd_index), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .cfg_clear(cfg_clear), .status_clr(status_clr), .count(count),
    .kp_event(kp_event), .err_flag(err_flag), .ovf_err(ovf_err), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    key_valid = 1'b0; rd_req = 1'b0; rd_peek = 1'b0;
    cfg_clear = 1'b0; status_clr = 1'b0;
  endtask

  task automatic set_push(input logic [7:0] ent);
    key_valid = 1'b1; key_press = ent[7]; key_code = ent[6:0];
  endtask

  task automatic set_read(input logic peek, input logic [4:0] idx);
    rd_req = 1'b1; rd_peek = peek; rd_index = idx;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    chk("R12 count", count, 0);
    chk("R12 ready", key_ready, 1);
    chk("R12 irq", irq, 0);
    chk("R12 ovf", ovf_err, 0);
    chk("R12 rsp_valid", rd_rsp_valid, 0);

    // Vector walk: R1 storage, R6 pop refusal, R7 pop, R8 peek
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      if (v[27:26] == 2'd0) set_push(v[25:18]);
      else set_read(v[27:26] == 2'd2, v[17:13]);
      tick();
      chk($sformatf("R1/R6/R7/R8 vec%0d count", i), count, int'(v[12:8]));
      if (v[27:26] != 2'd0) begin
        chk($sformatf("R12 vec%0d rsp_valid", i), rd_rsp_valid, 1);
        chk($sformatf("R6/R7/R8 vec%0d data", i), rd_rsp_data, int'(v[7:0]));
      end
    end

    // R5 status and interrupt
    chk("R5 kp_event", kp_event, 1);
    chk("R5 irq", irq, 1);
    status_clr = 1'b1; tick();
    chk("R11 kp cleared", kp_event, 0);
    chk("R11 irq low", irq, 0);

    // R9 clear ignores same-cycle push and read
    cfg_clear = 1'b1; set_push(8'h44); set_read(1'b1, 5'd0); tick();
    chk("R9 count", count, 0);
    chk("R9 kp", kp_event, 0);
    chk("R9 no rsp", rd_rsp_valid, 0);
    set_read(1'b1, 5'd0); tick();
    chk("R9 peek empty", rd_rsp_data, 0);

    // Fill to 16
    for (int i = 0; i < 16; i++) begin
      set_push({i[0], 7'(8'h20 + i)}); tick();
    end
    chk("R1 full count", count, 16);
    chk("R2 ready low at full", key_ready, 0);
    set_read(1'b1, 5'd15); tick();
    chk("R1 peek last", rd_rsp_data, 8'hAF);
    set_read(1'b1, 5'd16); tick();
    chk("R8 peek idx16", rd_rsp_data, 0);
    set_push(8'hFF); tick();
    chk("R3 count held", count, 16);
    chk("R3 ovf_err", ovf_err, 1);
    chk("R3 err_flag", err_flag, 1);

    set_read(1'b0, 5'd0); tick();
    chk("R7 pop data", rd_rsp_data, 8'hA1);
    chk("R7 pop count", count, 15);
    chk("R2 ready low while suppressed", key_ready, 0);
    set_push(8'h01); tick();
    chk("R4 dropped count", count, 15);
    set_read(1'b1, 5'd14); tick();
    chk("R4 contents intact", rd_rsp_data, 8'hAF);

    status_clr = 1'b1; tick();
    chk("R11 err cleared", err_flag, 0);
    chk("R11 ovf sticky", ovf_err, 1);
    chk("R2 ready back", key_ready, 1);
    set_push(8'h05); tick();
    chk("R1 refill count", count, 16);
    set_read(1'b1, 5'd15); tick();
    chk("R13 wrap peek", rd_rsp_data, 8'h05);

    // R10 pop+push at full: push overflows
    set_push(8'h66); set_read(1'b0, 5'd0); tick();
    chk("R10 full pop data", rd_rsp_data, 8'h22);
    chk("R10 full count", count, 15);
    chk("R10 full err", err_flag, 1);

    status_clr = 1'b1; tick();
    set_push(8'h66); set_read(1'b0, 5'd0); tick();
    chk("R10 pop data", rd_rsp_data, 8'hA3);
    chk("R10 count same", count, 15);
    set_read(1'b1, 5'd14); tick();
    chk("R13 wrap tail", rd_rsp_data, 8'h66);
    set_read(1'b1, 5'd15); tick();
    chk("R8 peek at count", rd_rsp_data, 0);

    // R11 set wins over acknowledge
    status_clr = 1'b1; tick();
    status_clr = 1'b1; set_push(8'h10); tick();
    chk("R11 set wins", kp_event, 1);
    chk("R11 count", count, 16);

    // R12 reset again
    rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1;
    chk("R12 count after reset", count, 0);
    chk("R12 ovf after reset", ovf_err, 0);
    chk("R12 kp after reset", kp_event, 0);
    chk("R12 ready after reset", key_ready, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule